// File: doc/BRIEF.md
# UART Interrupt Identification Logic

This block ranks the interrupt sources of a 16550-style UART, gates each one with its enable bit, and reports one registered interrupt request together with a 4-bit identification code. Four sources feed it. The line-status source is raised by overrun, parity, framing and break events. The receive data source has two causes: a data-ready condition, and a receive time-out condition that exists only in FIFO mode. The fourth source is a transmit-holding-empty condition. The serial shifter, the baud generator and the FIFO storage are outside the block and drive its status inputs.

Each source is cleared by its own event. A line-status read clears the overrun cause. The character-error cause stays until no erroneous character remains unread. In non-FIFO mode a receive buffer read clears the received character. In FIFO mode the data-ready condition follows the FIFO level. The transmit-empty source is cleared by a holding-register write. It is also cleared by an identification-register read made while the code it reports is the transmit-empty code. After that read it stays quiet until the transmitter next becomes empty.

Top module: `uart_irq_ident`

## Requirements
- R1: The bench releases reset with no source pending, and the outputs are then irq_o = 0 and iid_o = 4'b0001. Whenever a pending source is enabled, irq_o is 1 and bit 0 of iid_o is 0.
- R2: Priority runs from highest to lowest: line status (code 4'b0110), then receive (data-ready 4'b0100, time-out 4'b1100), then transmit-empty (4'b0010). iid_o shows the highest enabled pending source.
- R3: Bit 2 of ier_i enables line status. Bit 1 enables transmit-empty. Bit 0 enables both data-ready and time-out. A disabled source never appears in iid_o and never raises irq_o.
- R4: A pulse on any bit of lsr_evt_i raises the line-status source. The bit order is overrun at 0, parity at 1, framing at 2 and break at 3.
- R5: The overrun cause clears on lsr_rd_i. If a new overrun pulse and lsr_rd_i arrive in the same cycle, the source stays pending.
- R6: The parity, framing and break cause is not cleared by lsr_rd_i. It clears in the first cycle in which rx_err_left_i is 0 and no new such event is present.
- R7: In non-FIFO mode (fifo_en_i = 0), a pulse on rx_char_i sets data-ready. Data-ready then holds until rbr_rd_i.
- R8: In FIFO mode, data-ready is pending exactly while rx_level_i is nonzero and rx_level_i >= rx_trig_i. In this mode rx_char_i has no effect.
- R9: Time-out (4'b1100) is reported only in FIFO mode while rx_timeout_i is 1. When data-ready and time-out are both pending, data-ready is reported.
- R10: Transmit-empty is set when tx_empty_i goes from 0 to 1. It clears on thr_wr_i, on tx_empty_i falling, or on iir_rd_i in a cycle where iid_o is 4'b0010.
- R11: Once cleared by an identification read, transmit-empty stays clear while tx_empty_i stays 1. It re-arms on the next 0-to-1 transition of tx_empty_i. An iid_o read while another code is shown does not clear it.
- R12: Consider a status or strobe input present at clock edge k. It reaches irq_o and iid_o after edge k+1, so the outputs still show the old value between edges k and k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lsr_evt_i | input | CAUSE_N | Line error event pulses: bit 0 overrun, 1 parity, 2 framing, 3 break |
| rx_err_left_i | input | 1 | At least one erroneous character is still unread |
| rx_char_i | input | 1 | Character received pulse (non-FIFO mode) |
| rx_level_i | input | LVL_W | Receive FIFO fill level |
| rx_trig_i | input | LVL_W | Receive FIFO trigger level |
| rx_timeout_i | input | 1 | Receive time-out condition from the character timer |
| tx_empty_i | input | 1 | Transmit holding register or FIFO is empty |
| ier_i | input | 3 | Enables: bit 0 receive, bit 1 transmit-empty, bit 2 line status |
| fifo_en_i | input | 1 | FIFO mode selected |
| lsr_rd_i | input | 1 | Line status register read strobe |
| rbr_rd_i | input | 1 | Receive buffer read strobe |
| thr_wr_i | input | 1 | Transmit holding register write strobe |
| iir_rd_i | input | 1 | Identification register read strobe |
| irq_o | output | 1 | Interrupt request |
| iid_o | output | 4 | Identification code |

## Verification
Two pairs of events can meet in one cycle. The first pair is a new overrun pulse and a line-status read. The bench drives both on the same edge and expects code 4'b0110 to stay, then clears it with a read alone. The second pair is an identification read and the transmit-empty source while a higher source holds iid_o. The bench raises an overrun over an armed transmit-empty source and reads the identification register while 4'b0110 is shown. It then clears the line status and expects 4'b0010 to come back. A separate check counts edges to confirm the two-edge latency.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

   typedef enum logic [3:0] {
      IID_NONE = 4'b0001,
      IID_LSR  = 4'b0110,
      IID_RXD  = 4'b0100,
      IID_RTO  = 4'b1100,
      IID_THR  = 4'b0010
   } iid_e;

   localparam int unsigned IER_W    = 3;
   localparam int unsigned IER_RX   = 0;
   localparam int unsigned IER_THR  = 1;
   localparam int unsigned IER_LSR  = 2;

   localparam int unsigned CAUSE_OVR = 0;

endpackage

// File: rtl/uart_irq_lsr.sv
module uart_irq_lsr #(
   parameter int unsigned CAUSE_N = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [CAUSE_N-1:0] evt_i,
   input  logic               lsr_rd_i,
   input  logic               err_left_i,
   output logic               pend_o
);
   import uart_irq_pkg::*;

   localparam int unsigned CHR_N = CAUSE_N - 1;

   logic             ovr_q;
   logic             chr_q;
   logic [CHR_N-1:0] chr_evt;
   logic             chr_any;

   // character-attached causes occupy every bit above the overrun bit
   for (genvar g = 0; g < CHR_N; g++) begin : g_chr
      assign chr_evt[g] = evt_i[g+1];
   end

   assign chr_any = |chr_evt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ovr_q <= 1'b0;
         chr_q <= 1'b0;
      end else begin
         // a fresh overrun outranks a simultaneous status read
         ovr_q <= evt_i[CAUSE_OVR] | (ovr_q & ~lsr_rd_i);
         // held until the erroneous characters are drained
         chr_q <= chr_any | (chr_q & err_left_i);
      end
   end

   assign pend_o = ovr_q | chr_q;

endmodule

// File: rtl/uart_irq_rx.sv
module uart_irq_rx #(
   parameter int unsigned LVL_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fifo_en_i,
   input  logic             char_i,
   input  logic             rbr_rd_i,
   input  logic [LVL_W-1:0] level_i,
   input  logic [LVL_W-1:0] trig_i,
   input  logic             timeout_i,
   output logic             dr_o,
   output logic             to_o
);

   localparam logic [LVL_W-1:0] LVL_ZERO = '0;

   logic nf_q;
   logic ff_q;
   logic to_q;
   logic at_trig;

   assign at_trig = (level_i != LVL_ZERO) && (level_i >= trig_i);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         nf_q <= 1'b0;
         ff_q <= 1'b0;
         to_q <= 1'b0;
      end else begin
         nf_q <= ~fifo_en_i & (char_i | (nf_q & ~rbr_rd_i));
         ff_q <= fifo_en_i & at_trig;
         to_q <= fifo_en_i & timeout_i;
      end
   end

   assign dr_o = nf_q | ff_q;
   assign to_o = to_q;

endmodule

// File: rtl/uart_irq_thr.sv
module uart_irq_thr (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tx_empty_i,
   input  logic       thr_wr_i,
   input  logic       iir_rd_i,
   input  logic [3:0] iid_i,
   output logic       pend_o
);
   import uart_irq_pkg::*;

   logic prev_q;
   logic arm_q;
   logic rise;
   logic rd_clr;

   assign rise   = tx_empty_i & ~prev_q;
   assign rd_clr = iir_rd_i & (iid_i == IID_THR);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         arm_q  <= 1'b0;
      end else begin
         prev_q <= tx_empty_i;
         arm_q  <= rise | (arm_q & tx_empty_i & ~thr_wr_i & ~rd_clr);
      end
   end

   assign pend_o = arm_q;

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio #(
   parameter bit RX_TO_FIRST = 1'b0
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [uart_irq_pkg::IER_W-1:0] ier_i,
   input  logic                           ls_i,
   input  logic                           dr_i,
   input  logic                           to_i,
   input  logic                           thr_i,
   output logic                           irq_o,
   output logic [3:0]                     iid_o
);
   import uart_irq_pkg::*;

   logic ls_en;
   logic rx_en;
   logic thr_en;
   iid_e rx_code;
   iid_e code;

   assign ls_en  = ier_i[IER_LSR] & ls_i;
   assign rx_en  = ier_i[IER_RX]  & (dr_i | to_i);
   assign thr_en = ier_i[IER_THR] & thr_i;

   // tie order inside the shared receive level
   if (RX_TO_FIRST) begin : g_to_first
      assign rx_code = to_i ? IID_RTO : IID_RXD;
   end else begin : g_dr_first
      assign rx_code = dr_i ? IID_RXD : IID_RTO;
   end

   always_comb begin
      code = IID_NONE;
      if (ls_en)       code = IID_LSR;
      else if (rx_en)  code = rx_code;
      else if (thr_en) code = IID_THR;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         iid_o <= IID_NONE;
         irq_o <= 1'b0;
      end else begin
         iid_o <= code;
         irq_o <= ls_en | rx_en | thr_en;
      end
   end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident #(
   parameter int unsigned LVL_W       = 5,
   parameter int unsigned CAUSE_N     = 4,
   parameter bit          RX_TO_FIRST = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [CAUSE_N-1:0] lsr_evt_i,
   input  logic               rx_err_left_i,
   input  logic               rx_char_i,
   input  logic [LVL_W-1:0]   rx_level_i,
   input  logic [LVL_W-1:0]   rx_trig_i,
   input  logic               rx_timeout_i,
   input  logic               tx_empty_i,
   input  logic [2:0]         ier_i,
   input  logic               fifo_en_i,
   input  logic               lsr_rd_i,
   input  logic               rbr_rd_i,
   input  logic               thr_wr_i,
   input  logic               iir_rd_i,
   output logic               irq_o,
   output logic [3:0]         iid_o
);

   if (LVL_W < 1) begin : g_bad_lvl
      $error("uart_irq_ident: LVL_W must be at least 1");
   end
   if (CAUSE_N < 2) begin : g_bad_cause
      $error("uart_irq_ident: CAUSE_N needs overrun plus one character cause");
   end

   logic ls_pend;
   logic dr_pend;
   logic to_pend;
   logic thr_pend;

   uart_irq_lsr #(.CAUSE_N(CAUSE_N)) u_lsr (
      .clk        (clk),
      .rst_n      (rst_n),
      .evt_i      (lsr_evt_i),
      .lsr_rd_i   (lsr_rd_i),
      .err_left_i (rx_err_left_i),
      .pend_o     (ls_pend)
   );

   uart_irq_rx #(.LVL_W(LVL_W)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .fifo_en_i (fifo_en_i),
      .char_i    (rx_char_i),
      .rbr_rd_i  (rbr_rd_i),
      .level_i   (rx_level_i),
      .trig_i    (rx_trig_i),
      .timeout_i (rx_timeout_i),
      .dr_o      (dr_pend),
      .to_o      (to_pend)
   );

   uart_irq_thr u_thr (
      .clk        (clk),
      .rst_n      (rst_n),
      .tx_empty_i (tx_empty_i),
      .thr_wr_i   (thr_wr_i),
      .iir_rd_i   (iir_rd_i),
      .iid_i      (iid_o),
      .pend_o     (thr_pend)
   );

   uart_irq_prio #(.RX_TO_FIRST(RX_TO_FIRST)) u_prio (
      .clk   (clk),
      .rst_n (rst_n),
      .ier_i (ier_i),
      .ls_i  (ls_pend),
      .dr_i  (dr_pend),
      .to_i  (to_pend),
      .thr_i (thr_pend),
      .irq_o (irq_o),
      .iid_o (iid_o)
   );

endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk #(
   parameter int unsigned CAUSE_N = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic [CAUSE_N-1:0] lsr_evt_i,
   input logic [2:0]         ier_i,
   input logic               fifo_en_i,
   input logic               tx_empty_i,
   input logic               iir_rd_i,
   input logic               irq_o,
   input logic [3:0]         iid_o
);

   // R1: nothing enabled leaves the idle code on the next cycle
   a_r1_idle_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
      (ier_i == 3'b000) |=> (iid_o == 4'b0001 && !irq_o));

   // R2: an enabled overrun wins over every other source two edges later
   a_r2_lsr_on_top: assert property (@(posedge clk) disable iff (!rst_n)
      (ier_i[2] && lsr_evt_i[0]) ##1 ier_i[2] |=> (iid_o == 4'b0110 && irq_o));

   // R3: transmit-empty never reported with its enable off
   a_r3_thr_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (!ier_i[1] && !$past(ier_i[1])) |-> (iid_o != 4'b0010));

   // R9: time-out code needs FIFO mode
   a_r9_timeout_fifo_only: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(fifo_en_i) && !$past(fifo_en_i, 2)) |-> (iid_o != 4'b1100));

   // R10: reading the code while it shows transmit-empty removes it
   a_r10_iir_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (iid_o == 4'b0010 && iir_rd_i && tx_empty_i && $past(tx_empty_i))
      |=> ##1 (iid_o != 4'b0010));

endmodule

bind uart_irq_ident uart_irq_ident_chk #(.CAUSE_N(CAUSE_N)) u_chk (.*);

// File: tb/uart_irq_ident_tb.sv
module uart_irq_ident_tb;

   localparam int unsigned LVL_W   = 5;
   localparam int unsigned CAUSE_N = 4;

   typedef struct packed {
      logic [2:0]       ier;
      logic             fifo;
      logic             txe;
      logic [LVL_W-1:0] lvl;
      logic [LVL_W-1:0] trig;
      logic             to;
      logic [3:0]       iid;
      logic [3:0]       req;
   } vec_t;

   localparam int NVEC = 12;
   localparam vec_t VECS [NVEC] = '{
      '{3'b000, 1'b0, 1'b1, 5'd0,  5'd4,  1'b0, 4'b0001, 4'd3},  // R3 all off
      '{3'b010, 1'b0, 1'b1, 5'd0,  5'd4,  1'b0, 4'b0010, 4'd10}, // R10 empty
      '{3'b001, 1'b1, 1'b1, 5'd4,  5'd4,  1'b0, 4'b0100, 4'd8},  // R8 at trigger
      '{3'b011, 1'b1, 1'b1, 5'd4,  5'd4,  1'b0, 4'b0100, 4'd2},  // R2 rx over thr
      '{3'b011, 1'b1, 1'b1, 5'd3,  5'd4,  1'b0, 4'b0010, 4'd8},  // R8 below
      '{3'b011, 1'b1, 1'b0, 5'd3,  5'd4,  1'b1, 4'b1100, 4'd9},  // R9 timeout
      '{3'b001, 1'b1, 1'b0, 5'd5,  5'd4,  1'b1, 4'b0100, 4'd9},  // R9 tie
      '{3'b001, 1'b0, 1'b0, 5'd0,  5'd4,  1'b1, 4'b0001, 4'd9},  // R9 non-FIFO
      '{3'b110, 1'b1, 1'b1, 5'd8,  5'd4,  1'b1, 4'b0010, 4'd3},  // R3 rx off
      '{3'b001, 1'b1, 1'b0, 5'd0,  5'd0,  1'b0, 4'b0001, 4'd8},  // R8 empty fifo
      '{3'b011, 1'b1, 1'b1, 5'd1,  5'd1,  1'b0, 4'b0100, 4'd8},  // R8 trigger one
      '{3'b101, 1'b1, 1'b1, 5'd31, 5'd16, 1'b0, 4'b0100, 4'd3}   // R3 full fifo
   };

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [CAUSE_N-1:0] lsr_evt = '0;
   logic               rx_err_left = 1'b0;
   logic               rx_char = 1'b0;
   logic [LVL_W-1:0]   rx_level = '0;
   logic [LVL_W-1:0]   rx_trig = 5'd4;
   logic               rx_timeout = 1'b0;
   logic               tx_empty = 1'b0;
   logic [2:0]         ier = 3'b000;
   logic               fifo_en = 1'b0;
   logic               lsr_rd = 1'b0;
   logic               rbr_rd = 1'b0;
   logic               thr_wr = 1'b0;
   logic               iir_rd = 1'b0;
   logic               irq;
   logic [3:0]         iid;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   uart_irq_ident #(.LVL_W(LVL_W), .CAUSE_N(CAUSE_N)) u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .lsr_evt_i     (lsr_evt),
      .rx_err_left_i (rx_err_left),
      .rx_char_i     (rx_char),
      .rx_level_i    (rx_level),
      .rx_trig_i     (rx_trig),
      .rx_timeout_i  (rx_timeout),
      .tx_empty_i    (tx_empty),
      .ier_i         (ier),
      .fifo_en_i     (fifo_en),
      .lsr_rd_i      (lsr_rd),
      .rbr_rd_i      (rbr_rd),
      .thr_wr_i      (thr_wr),
      .iir_rd_i      (iir_rd),
      .irq_o         (irq),
      .iid_o         (iid)
   );

   task automatic tick(input int n);
      repeat (n) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic chk(input int req, input logic [3:0] exp);
      logic e_irq;
      e_irq = (exp != 4'b0001);
      n_vec++;
      if (iid !== exp || irq !== e_irq) begin
         n_bad++;
         $display("FAIL R%0d: iid=%b irq=%b expected iid=%b irq=%b",
                  req, iid, irq, exp, e_irq);
      end
   endtask

   task automatic arm_tx();
      tx_empty = 1'b0;
      tick(1);
      tx_empty = 1'b1;
      tick(3);
   endtask

   initial begin
      #400000;
      if (!done) begin
         n_bad++;
         $display("FAIL R12: watchdog expired, actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      tick(4);
      chk(1, 4'b0001);                  // R1 inside reset
      rst_n = 1'b1;
      tick(3);
      chk(1, 4'b0001);                  // R1 after release, nothing enabled

      for (int i = 0; i < NVEC; i++) begin
         ier        = VECS[i].ier;
         fifo_en    = VECS[i].fifo;
         rx_level   = VECS[i].lvl;
         rx_trig    = VECS[i].trig;
         rx_timeout = VECS[i].to;
         tx_empty   = 1'b0;
         tick(1);
         tx_empty   = VECS[i].txe;
         tick(3);
         chk(int'(VECS[i].req), VECS[i].iid);
      end

      // quiet baseline
      fifo_en = 1'b0; rx_level = '0; rx_timeout = 1'b0; tx_empty = 1'b0;
      ier = 3'b100;
      tick(3);

      // R12: latency of one overrun pulse
      lsr_evt = 4'b0001;
      @(posedge clk); @(negedge clk);
      lsr_evt = 4'b0000;
      chk(12, 4'b0001);                 // R12 still old after first edge
      tick(1);
      chk(12, 4'b0110);                 // R12 new after second edge
      lsr_rd = 1'b1; tick(1); lsr_rd = 1'b0;
      tick(3);
      chk(5, 4'b0001);                  // R5 overrun cleared by status read

      // R5: overrun and status read collide
      lsr_evt = 4'b0001; lsr_rd = 1'b1; tick(1);
      lsr_evt = 4'b0000; lsr_rd = 1'b0; tick(3);
      chk(5, 4'b0110);
      lsr_rd = 1'b1; tick(1); lsr_rd = 1'b0; tick(3);
      chk(5, 4'b0001);

      // R4 and R6: parity, framing, break
      for (int b = 1; b < 4; b++) begin
         lsr_evt = 4'b0001 << b; rx_err_left = 1'b1; tick(1);
         lsr_evt = 4'b0000; tick(3);
         chk(4, 4'b0110);
         lsr_rd = 1'b1; tick(1); lsr_rd = 1'b0; tick(3);
         chk(6, 4'b0110);               // R6 status read does not clear
         rx_err_left = 1'b0; tick(3);
         chk(6, 4'b0001);
      end

      // R7: non-FIFO data-ready
      ier = 3'b001;
      rx_char = 1'b1; tick(1); rx_char = 1'b0; tick(3);
      chk(7, 4'b0100);
      tick(5);
      chk(7, 4'b0100);                  // R7 held without read
      rbr_rd = 1'b1; tick(1); rbr_rd = 1'b0; tick(3);
      chk(7, 4'b0001);

      // R8: character pulse ignored in FIFO mode
      fifo_en = 1'b1; rx_level = '0; rx_trig = 5'd4;
      tick(2);
      rx_char = 1'b1; tick(1); rx_char = 1'b0; tick(3);
      chk(8, 4'b0001);
      fifo_en = 1'b0; tick(2);

      // R10 and R11: transmit-empty clear and re-arm
      ier = 3'b010;
      arm_tx();
      chk(10, 4'b0010);
      iir_rd = 1'b1; tick(1); iir_rd = 1'b0; tick(3);
      chk(10, 4'b0001);
      tick(5);
      chk(11, 4'b0001);                 // R11 stays clear while empty
      arm_tx();
      chk(11, 4'b0010);                 // R11 re-armed by new transition
      thr_wr = 1'b1; tick(1); thr_wr = 1'b0; tick(3);
      chk(10, 4'b0001);                 // R10 holding write clears

      // R11: identification read under a higher source leaves it armed
      ier = 3'b110;
      arm_tx();
      chk(11, 4'b0010);
      lsr_evt = 4'b0001; tick(1); lsr_evt = 4'b0000; tick(3);
      chk(2, 4'b0110);                  // R2 line status over transmit
      iir_rd = 1'b1; tick(1); iir_rd = 1'b0; tick(1);
      lsr_rd = 1'b1; tick(1); lsr_rd = 1'b0; tick(3);
      chk(11, 4'b0010);

      // R2: all three levels stacked
      ier = 3'b111; fifo_en = 1'b1; rx_level = 5'd4; rx_trig = 5'd4;
      arm_tx();
      chk(2, 4'b0100);
      lsr_evt = 4'b0001; tick(1); lsr_evt = 4'b0000; tick(3);
      chk(2, 4'b0110);
      lsr_rd = 1'b1; tick(1); lsr_rd = 1'b0; tick(3);
      chk(2, 4'b0100);
      rx_level = '0; tick(3);
      chk(2, 4'b0010);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule